// File: doc/BRIEF.md
# Parking Slot Occupancy Controller

This block keeps track of which bays in a small parking area hold a vehicle. It reads one infrared sensor per bay plus one sensor at the entry lane and one at the exit lane. All sensors are active-low: a sensor reads 0 while it sees a vehicle. A three-state sequencer (Idle, Entry, Exit) decides when a bay change may be counted. A bay that becomes covered is counted only after the entry lane sensor has fired. A bay that becomes clear is counted only after the exit lane sensor has fired.

For each bay the block drives a status LED. It keeps an occupied count and a free count, which a separate text display reads. It also drives a two-digit common-anode seven-segment display through time-multiplexed, active-low segment and digit lines. While an arrival is in progress the display shows "et". While a departure is in progress it shows "ei". In Idle both digits are dark.

Top module: `parking_occupancy_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, every LED is off, the occupied count is 0, the free count equals NUM_SLOTS, and both digits show the blank code 8'hFF.
- R2: All sensor inputs are synchronized and active-low. From Idle, an entry sensor reading 0 moves the block to Entry, and an exit sensor reading 0 moves it to Exit. When both read 0 at once, Entry wins.
- R3: In Entry, a bay sensor going from 1 to 0 whose LED is off is accepted. The block turns that LED on, adds one to the occupied count, subtracts one from the free count and returns to Idle. If several bays fall in the same cycle, the lowest-numbered one is taken. At most one LED changes per cycle.
- R4: In Exit, a bay sensor going from 0 to 1 whose LED is on is accepted. The block turns that LED off, subtracts one from the occupied count, adds one to the free count and returns to Idle.
- R5: The following bay changes are ignored: any change in Idle, a change in the opposite direction to the pending event, and a change on a bay whose LED is already in the target state. The block stays in its current state and the LEDs and counts do not change.
- R6: The occupied count always equals the number of LEDs lit. The free count is always NUM_SLOTS minus the occupied count. The occupied count saturates at 0 and at NUM_SLOTS.
- R7: The segment bus is active-low with bit order {dp,g,f,e,d,c,b,a}. In Entry, digit 0 shows 8'h84 ("e") and digit 1 shows 8'h87 ("t"). In Exit, digit 0 shows 8'h84 and digit 1 shows 8'hFB ("i").
- R8: In Idle both digits show 8'hFF.
- R9: The digit-select bus is active-low. Digit 0 is selected by 4'b1110 and digit 1 by 4'b1101. Lines 3 and 2 stay high. The selected digit alternates every CLK_HZ/(2*REFRESH_HZ) cycles, which gives the display a full refresh at REFRESH_HZ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slot_sens_n | input | NUM_SLOTS | Bay sensors, 0 = vehicle present |
| entry_sens_n | input | 1 | Entry lane sensor, 0 = vehicle present |
| exit_sens_n | input | 1 | Exit lane sensor, 0 = vehicle present |
| slot_led | output | NUM_SLOTS | Bay status LEDs, 1 = occupied |
| seg_n | output | 8 | Active-low segments {dp,g,f,e,d,c,b,a} |
| dig_sel_n | output | 4 | Active-low digit select |
| occ_count | output | clog2(NUM_SLOTS+1) | Occupied bays |
| free_count | output | clog2(NUM_SLOTS+1) | Free bays |

## Verification
A sequencer stuck in the wrong state shows on the display within one digit period: a lit "et" or "ei" while the block should be idle, or dark digits during an event. A bay edge that is counted when it should be ignored, or dropped when it should be counted, shows on the LEDs and both counts about four clocks after the sensor changes. Both cases are caught by the next vector check. A wrong divider shows as a wrong count of cycles between digit-select changes.

// File: rtl/park_pkg.sv
package park_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ENTRY = 2'd1,
    ST_EXIT  = 2'd2
  } evt_state_e;

  // active-low glyphs, bit order {dp,g,f,e,d,c,b,a}
  localparam logic [7:0] GLYPH_E   = 8'h84;
  localparam logic [7:0] GLYPH_T   = 8'h87;
  localparam logic [7:0] GLYPH_I   = 8'hFB;
  localparam logic [7:0] GLYPH_OFF = 8'hFF;

  localparam logic [3:0] DSEL_D0 = 4'b1110;
  localparam logic [3:0] DSEL_D1 = 4'b1101;
endpackage

// File: rtl/sensor_sync.sv
module sensor_sync #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] meta_q;

  // idle level of an active-low sensor is 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      q_out  <= '1;
    end else begin
      meta_q <= d_in;
      q_out  <= meta_q;
    end
  end
endmodule

// File: rtl/occupancy_fsm.sv
module occupancy_fsm
  import park_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int CW        = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] slot_now,
  input  logic                 entry_low,
  input  logic                 exit_low,
  output evt_state_e           state,
  output logic [NUM_SLOTS-1:0] slot_led,
  output logic [CW-1:0]        occ_count,
  output logic [CW-1:0]        free_count
);
  evt_state_e           state_nxt;
  logic [NUM_SLOTS-1:0] slot_prev;
  logic [NUM_SLOTS-1:0] fall_ok, rise_ok, pick_fall, pick_rise;
  logic [NUM_SLOTS-1:0] led_nxt;
  logic [CW-1:0]        occ_nxt, free_nxt;
  logic                 upd_en;

  // eligible edges: covered bay with dark LED, cleared bay with lit LED
  assign fall_ok   = slot_prev & ~slot_now & ~slot_led;
  assign rise_ok   = ~slot_prev & slot_now & slot_led;
  // isolate the lowest set bit
  assign pick_fall = fall_ok & (~fall_ok + NUM_SLOTS'(1));
  assign pick_rise = rise_ok & (~rise_ok + NUM_SLOTS'(1));

  always_comb begin
    state_nxt = state;
    led_nxt   = slot_led;
    occ_nxt   = occ_count;
    free_nxt  = free_count;
    upd_en    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (entry_low)     state_nxt = ST_ENTRY;
        else if (exit_low) state_nxt = ST_EXIT;
      end
      ST_ENTRY: begin
        if ((|fall_ok) && (occ_count != CW'(NUM_SLOTS))) begin
          upd_en    = 1'b1;
          led_nxt   = slot_led | pick_fall;
          occ_nxt   = occ_count + CW'(1);
          free_nxt  = free_count - CW'(1);
          state_nxt = ST_IDLE;
        end
      end
      ST_EXIT: begin
        if ((|rise_ok) && (occ_count != '0)) begin
          upd_en    = 1'b1;
          led_nxt   = slot_led & ~pick_rise;
          occ_nxt   = occ_count - CW'(1);
          free_nxt  = free_count + CW'(1);
          state_nxt = ST_IDLE;
        end
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      slot_prev <= '1;
    end else begin
      state     <= state_nxt;
      slot_prev <= slot_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_led   <= '0;
      occ_count  <= '0;
      free_count <= CW'(NUM_SLOTS);
    end else if (upd_en) begin
      slot_led   <= led_nxt;
      occ_count  <= occ_nxt;
      free_count <= free_nxt;
    end
  end
endmodule

// File: rtl/seg_mux_driver.sv
module seg_mux_driver
  import park_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int REFRESH_HZ = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  evt_state_e state,
  output logic [7:0] seg_n,
  output logic [3:0] dig_sel_n
);
  localparam int DIG_CYC_RAW = CLK_HZ / (2 * REFRESH_HZ);
  localparam int DIG_CYC     = (DIG_CYC_RAW < 1) ? 1 : DIG_CYC_RAW;
  localparam int CNT_W       = (DIG_CYC < 2) ? 1 : $clog2(DIG_CYC);

  logic [CNT_W-1:0] div_cnt, div_nxt;
  logic             dig_idx;
  logic             tick;

  assign tick    = (div_cnt == CNT_W'(DIG_CYC - 1));
  assign div_nxt = tick ? '0 : div_cnt + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      dig_idx <= 1'b0;
    end else begin
      div_cnt <= div_nxt;
      if (tick) dig_idx <= ~dig_idx;
    end
  end

  always_comb begin
    dig_sel_n = dig_idx ? DSEL_D1 : DSEL_D0;
    case (state)
      ST_ENTRY: seg_n = dig_idx ? GLYPH_T : GLYPH_E;
      ST_EXIT:  seg_n = dig_idx ? GLYPH_I : GLYPH_E;
      default:  seg_n = GLYPH_OFF;
    endcase
  end
endmodule

// File: rtl/parking_occupancy_ctrl.sv
module parking_occupancy_ctrl
  import park_pkg::*;
#(
  parameter int NUM_SLOTS  = 4,
  parameter int CLK_HZ     = 50_000_000,
  parameter int REFRESH_HZ = 1000
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_SLOTS-1:0]               slot_sens_n,
  input  logic                               entry_sens_n,
  input  logic                               exit_sens_n,
  output logic [NUM_SLOTS-1:0]               slot_led,
  output logic [7:0]                         seg_n,
  output logic [3:0]                         dig_sel_n,
  output logic [$clog2(NUM_SLOTS+1)-1:0]     occ_count,
  output logic [$clog2(NUM_SLOTS+1)-1:0]     free_count
);
  localparam int CW = $clog2(NUM_SLOTS + 1);
  localparam int SW = NUM_SLOTS + 2;

  logic          rst_meta, rst_sync_n;
  logic [SW-1:0] sens_sync;
  evt_state_e    cur_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  sensor_sync #(.W(SW)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_in  ({exit_sens_n, entry_sens_n, slot_sens_n}),
    .q_out (sens_sync)
  );

  occupancy_fsm #(.NUM_SLOTS(NUM_SLOTS), .CW(CW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .slot_now   (sens_sync[NUM_SLOTS-1:0]),
    .entry_low  (~sens_sync[NUM_SLOTS]),
    .exit_low   (~sens_sync[NUM_SLOTS+1]),
    .state      (cur_state),
    .slot_led   (slot_led),
    .occ_count  (occ_count),
    .free_count (free_count)
  );

  seg_mux_driver #(.CLK_HZ(CLK_HZ), .REFRESH_HZ(REFRESH_HZ)) u_disp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .state     (cur_state),
    .seg_n     (seg_n),
    .dig_sel_n (dig_sel_n)
  );
endmodule

// File: rtl/park_occ_checker.sv
module park_occ_checker
  import park_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int CW        = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_SLOTS-1:0] slot_led,
  input logic [CW-1:0]        occ_count,
  input logic [CW-1:0]        free_count,
  input logic [7:0]           seg_n,
  input logic [3:0]           dig_sel_n,
  input evt_state_e           state
);
  assert_count_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(occ_count) + int'(free_count)) == NUM_SLOTS);

  assert_led_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_led) == int'(occ_count));

  assert_one_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_led ^ $past(slot_led)) <= 1);

  assert_no_lit_in_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXIT) |=> ((slot_led & ~$past(slot_led)) == '0));

  assert_entry_no_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ENTRY) |=> (state != ST_EXIT));

  assert_blank_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (seg_n == GLYPH_OFF));

  assert_digit_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_sel_n[3:2] == 2'b11) && ($countones(dig_sel_n[1:0]) == 1));
endmodule

bind parking_occupancy_ctrl park_occ_checker #(.NUM_SLOTS(NUM_SLOTS), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .slot_led   (slot_led),
  .occ_count  (occ_count),
  .free_count (free_count),
  .seg_n      (seg_n),
  .dig_sel_n  (dig_sel_n),
  .state      (cur_state)
);

// File: tb/test_parking_occupancy_ctrl.sv
`timescale 1ns/1ps
module test_parking_occupancy_ctrl;
  localparam int NS = 4;
  localparam int DIG_CYC = 4;       // 8000 / (2*1000)

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] slot_sens_n = '1;
  logic          entry_sens_n = 1'b1;
  logic          exit_sens_n = 1'b1;
  logic [NS-1:0] slot_led;
  logic [7:0]    seg_n;
  logic [3:0]    dig_sel_n;
  logic [2:0]    occ_count, free_count;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  parking_occupancy_ctrl #(.NUM_SLOTS(NS), .CLK_HZ(8000), .REFRESH_HZ(1000)) i_parking_occupancy_ctrl (
    .clk(clk), .rst_n(rst_n), .slot_sens_n(slot_sens_n), .entry_sens_n(entry_sens_n),
    .exit_sens_n(exit_sens_n), .slot_led(slot_led), .seg_n(seg_n), .dig_sel_n(dig_sel_n),
    .occ_count(occ_count), .free_count(free_count));

  // mode: 0 idle/blank, 1 arrival "et", 2 departure "ei"
  typedef struct packed {
    logic [3:0] slot_n;
    logic       ent_n;
    logic       ext_n;
    logic [3:0] led;
    logic [2:0] occ;
    logic [1:0] mode;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{4'b1111, 1'b0, 1'b1, 4'b0000, 3'd0, 2'd1}, // R2 entry
    '{4'b1110, 1'b1, 1'b1, 4'b0001, 3'd1, 2'd0}, // R3 bay0
    '{4'b1100, 1'b1, 1'b1, 4'b0001, 3'd1, 2'd0}, // R5 idle change
    '{4'b1100, 1'b0, 1'b1, 4'b0001, 3'd1, 2'd1}, // R2
    '{4'b1000, 1'b1, 1'b1, 4'b0101, 3'd2, 2'd0}, // R3 bay2
    '{4'b1000, 1'b1, 1'b0, 4'b0101, 3'd2, 2'd2}, // R2 exit
    '{4'b1010, 1'b1, 1'b1, 4'b0101, 3'd2, 2'd2}, // R5 dark LED rise
    '{4'b1011, 1'b1, 1'b1, 4'b0100, 3'd1, 2'd0}, // R4 bay0
    '{4'b1011, 1'b1, 1'b0, 4'b0100, 3'd1, 2'd2}, // R2
    '{4'b1111, 1'b1, 1'b1, 4'b0000, 3'd0, 2'd0}, // R4 bay2
    '{4'b1111, 1'b0, 1'b0, 4'b0000, 3'd0, 2'd1}, // R2 priority
    '{4'b0000, 1'b1, 1'b1, 4'b0001, 3'd1, 2'd0}, // R3 lowest wins
    '{4'b0000, 1'b0, 1'b1, 4'b0001, 3'd1, 2'd1}, // R2
    '{4'b0010, 1'b1, 1'b1, 4'b0001, 3'd1, 2'd1}, // R5 opposite dir
    '{4'b0000, 1'b1, 1'b1, 4'b0011, 3'd2, 2'd0}, // R3 bay1
    '{4'b1100, 1'b1, 1'b1, 4'b0011, 3'd2, 2'd0}, // R5 idle
    '{4'b1100, 1'b0, 1'b1, 4'b0011, 3'd2, 2'd1},
    '{4'b0100, 1'b1, 1'b1, 4'b1011, 3'd3, 2'd0}, // R3 bay3
    '{4'b0100, 1'b0, 1'b1, 4'b1011, 3'd3, 2'd1},
    '{4'b0000, 1'b1, 1'b1, 4'b1111, 3'd4, 2'd0}, // R6 full
    '{4'b0000, 1'b0, 1'b1, 4'b1111, 3'd4, 2'd1},
    '{4'b0001, 1'b1, 1'b1, 4'b1111, 3'd4, 2'd1}, // R5
    '{4'b0000, 1'b1, 1'b1, 4'b1111, 3'd4, 2'd1}  // R6 saturate at top
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_digit(input logic [3:0] sel);
    for (int k = 0; k < 4 * DIG_CYC && dig_sel_n != sel; k++) @(negedge clk);
  endtask

  task automatic check_disp(input logic [1:0] mode, input string req);
    logic [7:0] e0, e1;
    e0 = (mode == 2'd0) ? 8'hFF : 8'h84;
    e1 = (mode == 2'd0) ? 8'hFF : ((mode == 2'd1) ? 8'h87 : 8'hFB);
    wait_digit(4'b1110);
    chk(dig_sel_n == 4'b1110 && seg_n == e0, req, {dig_sel_n, seg_n}, {4'b1110, e0});
    wait_digit(4'b1101);
    chk(dig_sel_n == 4'b1101 && seg_n == e1, req, {dig_sel_n, seg_n}, {4'b1101, e1});
  endtask

  task automatic check_counts(input logic [3:0] led, input logic [2:0] occ, input string req);
    chk(slot_led == led, req, slot_led, led);
    chk(occ_count == occ && free_count == 3'(NS) - occ, req,
        {occ_count, free_count}, {occ, 3'(NS) - occ});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check_counts(4'b0000, 3'd0, "R1");
    chk(seg_n == 8'hFF, "R1", seg_n, 8'hFF);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_counts(4'b0000, 3'd0, "R1");
    check_disp(2'd0, "R1/R8");

    // R9 digit period
    begin
      logic [3:0] s0;
      int n;
      s0 = dig_sel_n;
      while (dig_sel_n == s0) @(negedge clk);
      s0 = dig_sel_n;
      n = 0;
      while (dig_sel_n == s0 && n < 100) begin @(negedge clk); n++; end
      chk(n == DIG_CYC, "R9", n, DIG_CYC);
    end

    // vector walk
    for (int i = 0; i < NV; i++) begin
      slot_sens_n  = VECS[i].slot_n;
      entry_sens_n = VECS[i].ent_n;
      exit_sens_n  = VECS[i].ext_n;
      repeat (8) @(negedge clk);
      check_counts(VECS[i].led, VECS[i].occ, $sformatf("R3/R4/R5/R6 vec%0d", i));
      check_disp(VECS[i].mode, $sformatf("R7/R8 vec%0d", i));
    end

    // R1: reset in the middle of an event
    rst_n = 1'b0;
    @(negedge clk);
    check_counts(4'b0000, 3'd0, "R1 mid-run");
    chk(seg_n == 8'hFF, "R1 mid-run", seg_n, 8'hFF);
    rst_n = 1'b1;
    entry_sens_n = 1'b1;
    repeat (8) @(negedge clk);
    check_disp(2'd0, "R1/R8 after reset");

    // R6 saturation at zero: departure with no lit LED
    exit_sens_n = 1'b0;
    repeat (8) @(negedge clk);
    check_disp(2'd2, "R2/R7 exit");
    exit_sens_n = 1'b1;
    slot_sens_n = 4'b1000;
    repeat (8) @(negedge clk);
    check_counts(4'b0000, 3'd0, "R6 floor");
    check_disp(2'd2, "R5 still exit");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule